// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Window

This block gives a host a way to reach a word-addressed internal memory through a handful of 32-bit registers. The host loads a read pointer or a write pointer, then streams data through the matching data register. Every access to a data register moves its own pointer on by one word, so a buffer can be dumped or filled without reloading the address. The read side keeps one word prefetched. The host read of that word stalls through `ready_o` only while the prefetched word is not yet valid.

A second path reaches a small file of peripheral registers. An address register holds a byte offset and a transfer size, so partial-word writes touch only the low bytes and partial-word reads come back zero-extended. A third path reaches the same file through a staging data register and a control word that carries an offset and an operation code. For a staged write, the host fills the data register first and then issues the control word.

The host port accepts one access per cycle when `req_i && ready_o`. Read data is valid in the cycle the read is accepted. The window memory has one cycle of read latency and is not reset. The peripheral file is reset to zero.

Top module: `indirect_window`

## Requirements
- R1: After reset the read pointer, write pointer, peripheral address registers, staging data and control word all read back as zero, and `ready_o` is high.
- R2: Writing register 0 loads the read pointer. The next accepted read of register 3 returns the memory word at that pointer.
- R3: Each accepted read of register 3 advances the read pointer by one. Back-to-back reads return consecutive words without a stall, and register 0 reads back the current read pointer.
- R4: Writing register 1 loads the write pointer. Each write to register 2 stores the word at the write pointer and advances it by one. Register 1 reads back the current write pointer.
- R5: The pointers are independent: data writes never move the read pointer, and data reads never move the write pointer.
- R6: Both pointers are log2(MEM_DEPTH) bits wide. They wrap modulo MEM_DEPTH, drop higher address bits when loaded, and read back zero-extended.
- R7: `ready_o` is low only during a read of register 3 while no valid prefetch is held. After a write to register 2, a read of register 3 in the next cycle stalls for exactly one cycle and returns data that includes that write.
- R8: The peripheral write address (register 4) and read address (register 5) hold a byte offset in bits 15:0 and a size code in bits 25:24. The word index is the offset bits above bit 1, and the size code is the byte count minus one. A write to register 6 updates only the low (size+1) bytes of the addressed word.
- R9: A read of register 7 returns the addressed word masked to its low (size+1) bytes, with the upper bytes zero.
- R10: Register 9 is a staging data word. Writing register 8 stores a control word whose offset is in bits 15:0 and whose operation code is in bits 29:28. Code 3 writes the staging word to the peripheral file at that offset. Code 2 loads the staging word from that offset. Codes 0 and 1 change neither the file nor the staging word. Register 8 reads back the last control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register select |
| wdata_i | input | 32 | Host write data |
| ready_o | output | 1 | Access accepted this cycle when high with req_i |
| rdata_o | output | 32 | Read data for the selected register |

## Verification
The checker watches four rules on every cycle:
- a stall happens only on a data read without a valid prefetch, and it clears one cycle later;
- each accepted data access steps its own pointer by exactly one, modulo depth, and leaves the other pointer alone;
- a pending refetch never coexists with a valid prefetch;
- single-byte peripheral reads have zero upper bytes.

Only the bench's scenarios can show that data lands at the right word. Those scenarios cover:
- stream order;
- byte-lane merging of partial writes;
- the staged control operations, including the ignored codes;
- freshness of a word read right after it was written.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int REG_AW = 4;
  localparam int DW     = 32;

  localparam logic [REG_AW-1:0] SEL_MRADDR = 4'd0;
  localparam logic [REG_AW-1:0] SEL_MWADDR = 4'd1;
  localparam logic [REG_AW-1:0] SEL_MWDAT  = 4'd2;
  localparam logic [REG_AW-1:0] SEL_MRDAT  = 4'd3;
  localparam logic [REG_AW-1:0] SEL_PWADDR = 4'd4;
  localparam logic [REG_AW-1:0] SEL_PRADDR = 4'd5;
  localparam logic [REG_AW-1:0] SEL_PWDAT  = 4'd6;
  localparam logic [REG_AW-1:0] SEL_PRDAT  = 4'd7;
  localparam logic [REG_AW-1:0] SEL_SCTRL  = 4'd8;
  localparam logic [REG_AW-1:0] SEL_SDATA  = 4'd9;

  localparam logic [1:0] OP_RD = 2'd2;
  localparam logic [1:0] OP_WR = 2'd3;

  function automatic logic [3:0] size_be(input logic [1:0] sz);
    logic [3:0] be;
    for (int i = 0; i < 4; i++) be[i] = (i <= int'(sz));
    return be;
  endfunction

  function automatic logic [DW-1:0] be_mask(input logic [3:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/win_mem.sv
module win_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/win_prph.sv
module win_prph #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   widx_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [AW-1:0]   ridx_a_i,
  output logic [DW-1:0]   rdata_a_o,
  input  logic [AW-1:0]   ridx_b_i,
  output logic [DW-1:0]   rdata_b_o
);
  localparam int NB = DW / 8;
  logic [DW-1:0] regs_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  regs_q[w][8*b +: 8] <= '0;
        else if (we_i && widx_i == AW'(w) && be_i[b]) regs_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_a_o = regs_q[ridx_a_i];
  assign rdata_b_o = regs_q[ridx_b_i];
endmodule

// File: rtl/win_pf.sv
module win_pf #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          pop_i,
  input  logic          wr_i,
  output logic [AW-1:0] rptr_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_raddr_o,
  output logic          valid_o,
  output logic          refetch_o
);
  logic [AW-1:0] rptr_q, rptr_d;
  logic          valid_q, refetch_q;

  // a data write may alias the prefetched word: refetch when the write port is idle
  assign mem_re_o = load_i | pop_i | (refetch_q & ~wr_i);

  always_comb begin
    rptr_d = rptr_q;
    if (load_i)     rptr_d = load_addr_i;
    else if (pop_i) rptr_d = rptr_q + 1'b1;
  end
  assign mem_raddr_o = rptr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q    <= '0;
      valid_q   <= 1'b0;
      refetch_q <= 1'b1;
    end else begin
      rptr_q <= rptr_d;
      if (mem_re_o)  valid_q <= 1'b1;
      else if (wr_i) valid_q <= 1'b0;
      if (wr_i)          refetch_q <= 1'b1;
      else if (mem_re_o) refetch_q <= 1'b0;
    end
  end

  assign rptr_o    = rptr_q;
  assign valid_o   = valid_q;
  assign refetch_o = refetch_q;
endmodule

// File: rtl/indirect_window.sv
module indirect_window
  import win_pkg::*;
#(
  parameter int MEM_DEPTH  = 256,
  parameter int PRPH_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ready_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int MAW = $clog2(MEM_DEPTH);
  localparam int PAW = $clog2(PRPH_DEPTH);

  logic acc, wr_acc, rd_acc;
  logic ld_rptr, pop, mwr;
  logic [MAW-1:0] rptr, wptr_q, mem_raddr;
  logic mem_re, pf_valid, refetch;
  logic [DW-1:0] mem_rdata;

  logic [15:0] pw_off_q, pr_off_q;
  logic [1:0]  pw_sz_q, pr_sz_q;
  logic [DW-1:0] sdata_q, sctrl_q;
  logic [1:0]  sop;
  logic        s_wr, s_rd;
  logic        p_we;
  logic [PAW-1:0] p_widx;
  logic [3:0]  p_be;
  logic [DW-1:0] p_wdata, p_rd_a, p_rd_b;

  assign ready_o = pf_valid | ~(req_i & ~we_i & (addr_i == SEL_MRDAT));
  assign acc     = req_i & ready_o;
  assign wr_acc  = acc & we_i;
  assign rd_acc  = acc & ~we_i;

  assign ld_rptr = wr_acc & (addr_i == SEL_MRADDR);
  assign mwr     = wr_acc & (addr_i == SEL_MWDAT);
  assign pop     = rd_acc & (addr_i == SEL_MRDAT);

  win_pf #(.AW(MAW)) u_pf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ld_rptr),
    .load_addr_i (wdata_i[MAW-1:0]),
    .pop_i       (pop),
    .wr_i        (mwr),
    .rptr_o      (rptr),
    .mem_re_o    (mem_re),
    .mem_raddr_o (mem_raddr),
    .valid_o     (pf_valid),
    .refetch_o   (refetch)
  );

  win_mem #(.DEPTH(MEM_DEPTH), .AW(MAW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mwr),
    .waddr_i (wptr_q),
    .wdata_i (wdata_i),
    .re_i    (mem_re),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  assign sop  = wdata_i[29:28];
  assign s_wr = wr_acc & (addr_i == SEL_SCTRL) & (sop == OP_WR);
  assign s_rd = wr_acc & (addr_i == SEL_SCTRL) & (sop == OP_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      pw_off_q <= '0;
      pw_sz_q  <= '0;
      pr_off_q <= '0;
      pr_sz_q  <= '0;
      sdata_q  <= '0;
      sctrl_q  <= '0;
    end else begin
      if (wr_acc && addr_i == SEL_MWADDR) wptr_q <= wdata_i[MAW-1:0];
      else if (mwr)                       wptr_q <= wptr_q + 1'b1;
      if (wr_acc && addr_i == SEL_PWADDR) begin
        pw_off_q <= wdata_i[15:0];
        pw_sz_q  <= wdata_i[25:24];
      end
      if (wr_acc && addr_i == SEL_PRADDR) begin
        pr_off_q <= wdata_i[15:0];
        pr_sz_q  <= wdata_i[25:24];
      end
      if (wr_acc && addr_i == SEL_SCTRL) sctrl_q <= wdata_i;
      if (wr_acc && addr_i == SEL_SDATA) sdata_q <= wdata_i;
      else if (s_rd)                     sdata_q <= p_rd_b;
    end
  end

  always_comb begin
    p_we    = 1'b0;
    p_widx  = pw_off_q[PAW+1:2];
    p_be    = size_be(pw_sz_q);
    p_wdata = wdata_i;
    if (wr_acc && addr_i == SEL_PWDAT) begin
      p_we = 1'b1;
    end else if (s_wr) begin
      p_we    = 1'b1;
      p_widx  = wdata_i[PAW+1:2];
      p_be    = 4'hF;
      p_wdata = sdata_q;
    end
  end

  win_prph #(.DEPTH(PRPH_DEPTH), .AW(PAW), .DW(DW)) u_prph (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (p_we),
    .widx_i    (p_widx),
    .be_i      (p_be),
    .wdata_i   (p_wdata),
    .ridx_a_i  (pr_off_q[PAW+1:2]),
    .rdata_a_o (p_rd_a),
    .ridx_b_i  (wdata_i[PAW+1:2]),
    .rdata_b_o (p_rd_b)
  );

  always_comb begin
    unique case (addr_i)
      SEL_MRADDR: rdata_o = DW'(rptr);
      SEL_MWADDR: rdata_o = DW'(wptr_q);
      SEL_MRDAT:  rdata_o = mem_rdata;
      SEL_PWADDR: rdata_o = {6'b0, pw_sz_q, 8'b0, pw_off_q};
      SEL_PRADDR: rdata_o = {6'b0, pr_sz_q, 8'b0, pr_off_q};
      SEL_PRDAT:  rdata_o = p_rd_a & be_mask(size_be(pr_sz_q));
      SEL_SCTRL:  rdata_o = sctrl_q;
      SEL_SDATA:  rdata_o = sdata_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/win_chk.sv
module win_chk
  import win_pkg::*;
#(
  parameter int AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic              ready_o,
  input logic [DW-1:0]     rdata_o,
  input logic [AW-1:0]     rptr,
  input logic [AW-1:0]     wptr,
  input logic              pf_valid,
  input logic              refetch,
  input logic [1:0]        pr_sz
);
  logic data_rd, data_wr;
  assign data_rd = req_i & ~we_i & (addr_i == SEL_MRDAT) & ready_o;
  assign data_wr = req_i & we_i & (addr_i == SEL_MWDAT);

  p_stall_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (req_i && !we_i && addr_i == SEL_MRDAT));

  p_stall_short_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);

  p_refetch_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refetch |-> !pf_valid);

  // step is modulo 2**AW, which also covers R6
  p_rd_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd |=> rptr == AW'($past(rptr) + 1'b1));

  p_wr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> wptr == AW'($past(wptr) + 1'b1));

  p_wr_keeps_rptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> $stable(rptr));

  p_rd_keeps_wptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd |=> $stable(wptr));

  p_zext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == SEL_PRDAT && pr_sz == 2'd0) |-> rdata_o[31:8] == 24'd0);
endmodule

bind indirect_window win_chk #(.AW(MAW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .ready_o  (ready_o),
  .rdata_o  (rdata_o),
  .rptr     (rptr),
  .wptr     (wptr_q),
  .pf_valid (pf_valid),
  .refetch  (refetch),
  .pr_sz    (pr_sz_q)
);

// File: tb/sim_indirect_window.sv
module sim_indirect_window;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  indirect_window u0 (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .ready_o (ready), .rdata_o (rdata)
  );

  typedef struct packed {
    logic        w;
    logic [3:0]  a;
    logic [31:0] d;
    logic        c;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd1, 32'h10,       1'b0, 32'h0,       4'd4},  // R4
    '{1'b1, 4'd2, 32'hA0A0A0A0, 1'b0, 32'h0,       4'd4},
    '{1'b1, 4'd2, 32'hA1A1A1A1, 1'b0, 32'h0,       4'd4},
    '{1'b1, 4'd2, 32'hA2A2A2A2, 1'b0, 32'h0,       4'd4},
    '{1'b0, 4'd1, 32'h0,        1'b1, 32'h13,      4'd4},
    '{1'b1, 4'd0, 32'h10,       1'b0, 32'h0,       4'd2},  // R2
    '{1'b0, 4'd3, 32'h0,        1'b1, 32'hA0A0A0A0, 4'd2},
    '{1'b0, 4'd3, 32'h0,        1'b1, 32'hA1A1A1A1, 4'd3},  // R3
    '{1'b0, 4'd3, 32'h0,        1'b1, 32'hA2A2A2A2, 4'd3},
    '{1'b0, 4'd0, 32'h0,        1'b1, 32'h13,      4'd3},
    '{1'b0, 4'd1, 32'h0,        1'b1, 32'h13,      4'd5},  // R5
    '{1'b1, 4'd4, 32'h03000008, 1'b0, 32'h0,       4'd8},  // R8
    '{1'b1, 4'd6, 32'hDEADBEEF, 1'b0, 32'h0,       4'd8},
    '{1'b1, 4'd4, 32'h0000000C, 1'b0, 32'h0,       4'd8},
    '{1'b1, 4'd6, 32'h11223344, 1'b0, 32'h0,       4'd8},
    '{1'b1, 4'd5, 32'h0300000C, 1'b0, 32'h0,       4'd8},
    '{1'b0, 4'd7, 32'h0,        1'b1, 32'h00000044, 4'd8},
    '{1'b1, 4'd5, 32'h01000008, 1'b0, 32'h0,       4'd9},  // R9
    '{1'b0, 4'd7, 32'h0,        1'b1, 32'h0000BEEF, 4'd9},
    '{1'b1, 4'd4, 32'h01000008, 1'b0, 32'h0,       4'd8},
    '{1'b1, 4'd6, 32'h55667788, 1'b0, 32'h0,       4'd8},
    '{1'b1, 4'd5, 32'h03000008, 1'b0, 32'h0,       4'd8},
    '{1'b0, 4'd7, 32'h0,        1'b1, 32'hDEAD7788, 4'd8},
    '{1'b1, 4'd9, 32'hCAFEF00D, 1'b0, 32'h0,       4'd10}, // R10
    '{1'b1, 4'd8, 32'h30000014, 1'b0, 32'h0,       4'd10},
    '{1'b1, 4'd5, 32'h03000014, 1'b0, 32'h0,       4'd10},
    '{1'b0, 4'd7, 32'h0,        1'b1, 32'hCAFEF00D, 4'd10},
    '{1'b1, 4'd9, 32'h0,        1'b0, 32'h0,       4'd10},
    '{1'b1, 4'd8, 32'h20000008, 1'b0, 32'h0,       4'd10},
    '{1'b0, 4'd9, 32'h0,        1'b1, 32'hDEAD7788, 4'd10},
    '{1'b1, 4'd8, 32'h10000014, 1'b0, 32'h0,       4'd10},
    '{1'b0, 4'd9, 32'h0,        1'b1, 32'hDEAD7788, 4'd10},
    '{1'b1, 4'd9, 32'h0,        1'b0, 32'h0,       4'd10},
    '{1'b1, 4'd8, 32'h00000014, 1'b0, 32'h0,       4'd10},
    '{1'b0, 4'd7, 32'h0,        1'b1, 32'hCAFEF00D, 4'd10},
    '{1'b0, 4'd8, 32'h0,        1'b1, 32'h00000014, 4'd10}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int stalls);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    stalls = 0;
    while (!ready) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    q = rdata;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int st;
    do_reset();

    // R1 reset state
    #1;
    chk({31'b0, ready}, 32'd1, "R1 ready idle");
    access(1'b0, 4'd0, 32'h0, q, st); chk(q, 32'h0, "R1 rptr");
    access(1'b0, 4'd1, 32'h0, q, st); chk(q, 32'h0, "R1 wptr");
    access(1'b0, 4'd5, 32'h0, q, st); chk(q, 32'h0, "R1 praddr");
    access(1'b0, 4'd8, 32'h0, q, st); chk(q, 32'h0, "R1 sctrl");
    access(1'b0, 4'd9, 32'h0, q, st); chk(q, 32'h0, "R1 sdata");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].w, VEC[i].a, VEC[i].d, q, st);
      if (VEC[i].c) chk(q, VEC[i].e, $sformatf("R%0d vec %0d", VEC[i].r, i));
    end

    // R3 consecutive reads without stall
    access(1'b1, 4'd0, 32'h10, q, st);
    access(1'b0, 4'd3, 32'h0, q, st);
    access(1'b0, 4'd3, 32'h0, q, st);
    chk(q, 32'hA1A1A1A1, "R3 stream data");
    chk(st, 0, "R3 no stall");

    // R7 read right after write to the same word: one stall, fresh data
    access(1'b1, 4'd0, 32'h40, q, st);
    access(1'b1, 4'd1, 32'h40, q, st);
    access(1'b1, 4'd2, 32'h00000077, q, st);
    access(1'b0, 4'd3, 32'h0, q, st);
    chk(q, 32'h00000077, "R7 fresh data");
    chk(st, 1, "R7 stall count");

    // R6 wrap and truncation
    access(1'b1, 4'd1, 32'hFF, q, st);
    access(1'b1, 4'd2, 32'h000000AB, q, st);
    access(1'b1, 4'd2, 32'h000000CD, q, st);
    access(1'b0, 4'd1, 32'h0, q, st); chk(q, 32'h1, "R6 wptr wrap");
    access(1'b1, 4'd0, 32'h1FF, q, st);
    access(1'b0, 4'd0, 32'h0, q, st); chk(q, 32'hFF, "R6 rptr truncate");
    access(1'b0, 4'd3, 32'h0, q, st); chk(q, 32'hAB, "R6 last word");
    access(1'b0, 4'd3, 32'h0, q, st); chk(q, 32'hCD, "R6 wrapped word");
    access(1'b0, 4'd0, 32'h0, q, st); chk(q, 32'h1, "R6 rptr wrap");

    // R1 reset mid-run
    do_reset();
    access(1'b0, 4'd1, 32'h0, q, st); chk(q, 32'h0, "R1 wptr after reset");
    access(1'b0, 4'd7, 32'h0, q, st); chk(q, 32'h0, "R1 prph cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule